// File: doc/BRIEF.md
# Integer ALU with Flags

A 32-bit integer execution unit for a simple scalar core. Each accepted operation is given by an opcode, two register operands (`src_a`, the first source, and `src_b`, the second source and usual destination) and a 16-bit immediate field. The unit returns a result word, a register write enable, a four-bit flag vector and a four-bit mask that tells the flag register which bits to replace. Flags the mask leaves out keep their old value in the core's flag register.

Add, subtract, reverse subtract, compare, halfword multiply, the logical operations and the move forms all finish in one cycle, with a registered result. Halfword divide runs as a sequential restoring divider. While it runs, `op_ready` is low and any offered operation is ignored. The five-bit immediate is `imm[4:0]`.

Top module: `alu_flag_unit`

## Requirements
- R1: While reset is asserted and right after it, `res_valid` and `res_wr` are 0 and `op_ready` is 1.
- R2: The flag vector is `res_flags[0]`=Z, `[1]`=S, `[2]`=CY, `[3]`=OV. Bits outside `res_mask` read 0. Z is set when the 32-bit result is zero, and S equals result bit 31. Add computes `src_b + x`, where x is `src_a` for opcode 0, sign-extended `imm[4:0]` for opcode 1, and sign-extended `imm` for opcode 2. CY is the carry out of bit 31. OV is set when both addends share a sign and the sum's sign differs. The mask is 4'hF and the sum is written.
- R3: Subtract (opcode 3) computes `src_b - src_a`. Reverse subtract (opcode 4) computes `src_a - src_b`. CY is set when the minuend is below the subtrahend as unsigned numbers. OV is set when the operand signs differ and the result sign differs from the minuend. The mask is 4'hF and the result is written.
- R4: Compare computes `src_b - src_a` (opcode 5) or `src_b` minus sign-extended `imm[4:0]` (opcode 6). Its flags follow R3 with mask 4'hF. `res_wr` is 0, and `res_data` shows the difference.
- R5: Multiply takes the low 16 bits of `src_b` as unsigned and multiplies them by one of: the low 16 bits of `src_a` (opcode 7), sign-extended `imm[4:0]` (opcode 8), or zero-extended `imm` (opcode 9). The low 32 bits of the product are written with mask 0.
- R6: AND (11), OR (13), XOR (15) and NOT (17, giving `~src_a`) on registers, and OR-immediate (14) and XOR-immediate (16) with zero-extended `imm`, write the result. They use mask 4'b1011: Z and S come from the result, OV is cleared, and CY is left untouched.
- R7: AND-immediate (opcode 12) writes `src_b & zext(imm)`, uses mask 4'b1011, and always clears S.
- R8: Move forms write with mask 0. Opcode 18 writes `src_a`. Opcode 19 writes sign-extended `imm[4:0]`. Opcode 20 writes `src_b + sext(imm)`. Opcode 21 writes `src_b + (imm << 16)`.
- R9: Divide (opcode 10) writes the signed quotient of `src_b` by the sign-extended `src_a[15:0]`, truncated toward zero. It uses mask 4'b1011 with OV 0 and leaves CY untouched.
- R10: Dividing 32'h8000_0000 by -1 writes 32'h8000_0000 and sets OV and S, with mask 4'b1011.
- R11: A divisor of zero gives `res_wr` 0, mask 4'b1000, flags 4'b1000 and data 0.
- R12: A non-divide operation accepted at one clock edge has its `res_valid` pulse at the next edge. From the edge that accepts a divide until its result appears, `op_ready` is 0, and operations offered during that time produce no result.
- R13: Opcodes 22 to 31 give a result pulse with `res_wr` 0 and mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is offered |
| op_code | input | 5 | Operation select |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| op_ready | output | 1 | Unit can accept an operation |
| res_valid | output | 1 | Result pulse |
| res_data | output | 32 | Result value |
| res_wr | output | 1 | Write result to destination |
| res_flags | output | 4 | New flag values {OV,CY,S,Z} |
| res_mask | output | 4 | Flags to update |

## Verification
On every cycle, the assertions check the following properties. Single-cycle operations take exactly one cycle, and a started divide drops `op_ready`. Compare never writes, and multiply never touches flags. Logical operations keep CY and clear OV. A zero divisor never writes. Z always agrees with written data, the register-add overflow matches the operand signs, and undefined opcodes stay inert. Only the bench scenarios can show the actual arithmetic values: carries, borrows, sign-extension choices, quotient rounding, the overflowing divide, and the fact that an operation offered during a divide is dropped rather than queued.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int OP_W  = 5;
  localparam int FLG_W = 4;
  localparam int FZ = 0;
  localparam int FS = 1;
  localparam int FC = 2;
  localparam int FV = 3;

  localparam logic [FLG_W-1:0] MSK_NONE  = 4'b0000;
  localparam logic [FLG_W-1:0] MSK_ARITH = 4'b1111;
  localparam logic [FLG_W-1:0] MSK_LOGIC = 4'b1011;
  localparam logic [FLG_W-1:0] MSK_DZERO = 4'b1000;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_R    = 5'd0,
    OP_ADD_I5   = 5'd1,
    OP_ADD_I16  = 5'd2,
    OP_SUB_R    = 5'd3,
    OP_RSUB_R   = 5'd4,
    OP_CMP_R    = 5'd5,
    OP_CMP_I5   = 5'd6,
    OP_MUL_R    = 5'd7,
    OP_MUL_I5   = 5'd8,
    OP_MUL_I16  = 5'd9,
    OP_DIV_R    = 5'd10,
    OP_AND_R    = 5'd11,
    OP_AND_I16  = 5'd12,
    OP_OR_R     = 5'd13,
    OP_OR_I16   = 5'd14,
    OP_XOR_R    = 5'd15,
    OP_XOR_I16  = 5'd16,
    OP_NOT_R    = 5'd17,
    OP_MOV_R    = 5'd18,
    OP_MOV_I5   = 5'd19,
    OP_MOVA_I16 = 5'd20,
    OP_MOVH_I16 = 5'd21
  } alu_op_e;
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SIMM_W = 5
) (
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] ext_s5,
  output logic [DATA_W-1:0] ext_s16,
  output logic [DATA_W-1:0] ext_z16,
  output logic [DATA_W-1:0] ext_hi
);
  localparam int PAD_S = DATA_W - SIMM_W;
  localparam int PAD_L = DATA_W - IMM_W;

  assign ext_s5  = {{PAD_S{imm[SIMM_W-1]}}, imm[SIMM_W-1:0]};
  assign ext_s16 = {{PAD_L{imm[IMM_W-1]}}, imm};
  assign ext_z16 = {{PAD_L{1'b0}}, imm};
  assign ext_hi  = {imm, {PAD_L{1'b0}}};
endmodule

// File: rtl/alu_single_cycle.sv
module alu_single_cycle
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] ext_s5,
  input  logic [DATA_W-1:0] ext_s16,
  input  logic [DATA_W-1:0] ext_z16,
  input  logic [DATA_W-1:0] ext_hi,
  output logic [DATA_W-1:0] res,
  output logic              wr,
  output logic [FLG_W-1:0]  flg,
  output logic [FLG_W-1:0]  msk
);
  localparam int HALF = DATA_W / 2;
  localparam int AW   = DATA_W + 2;

  // {ov, carry, sum}
  function automatic logic [AW-1:0] add_core(input logic [DATA_W-1:0] x,
                                             input logic [DATA_W-1:0] y);
    logic [DATA_W:0] s;
    logic            v;
    s = {1'b0, x} + {1'b0, y};
    v = (x[DATA_W-1] == y[DATA_W-1]) && (s[DATA_W-1] != x[DATA_W-1]);
    return {v, s};
  endfunction

  // {ov, borrow, difference} for minuend m, subtrahend d
  function automatic logic [AW-1:0] sub_core(input logic [DATA_W-1:0] m,
                                             input logic [DATA_W-1:0] d);
    logic [DATA_W:0] r;
    logic            v;
    r = {1'b0, m} - {1'b0, d};
    v = (m[DATA_W-1] != d[DATA_W-1]) && (r[DATA_W-1] != m[DATA_W-1]);
    return {v, r};
  endfunction

  function automatic logic [FLG_W-1:0] arith_flags(input logic [AW-1:0] a);
    return {a[DATA_W+1], a[DATA_W], a[DATA_W-1], a[DATA_W-1:0] == '0};
  endfunction

  function automatic logic [FLG_W-1:0] logic_flags(input logic [DATA_W-1:0] r);
    return {2'b00, r[DATA_W-1], r == '0};
  endfunction

  function automatic logic [DATA_W-1:0] half_mul(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    logic [DATA_W-1:0] lo;
    lo = {{HALF{1'b0}}, x[HALF-1:0]};
    return lo * y;
  endfunction

  logic [AW-1:0]     arith;
  logic [DATA_W-1:0] a_low;

  assign a_low = {{HALF{1'b0}}, src_a[HALF-1:0]};

  always_comb begin
    arith = '0;
    case (op)
      OP_ADD_R:   arith = add_core(src_b, src_a);
      OP_ADD_I5:  arith = add_core(src_b, ext_s5);
      OP_ADD_I16: arith = add_core(src_b, ext_s16);
      OP_SUB_R:   arith = sub_core(src_b, src_a);
      OP_RSUB_R:  arith = sub_core(src_a, src_b);
      OP_CMP_R:   arith = sub_core(src_b, src_a);
      OP_CMP_I5:  arith = sub_core(src_b, ext_s5);
      default:    arith = '0;
    endcase
  end

  always_comb begin
    res = '0;
    wr  = 1'b0;
    flg = '0;
    msk = MSK_NONE;
    case (op)
      OP_ADD_R, OP_ADD_I5, OP_ADD_I16, OP_SUB_R, OP_RSUB_R: begin
        res = arith[DATA_W-1:0];
        wr  = 1'b1;
        flg = arith_flags(arith);
        msk = MSK_ARITH;
      end
      OP_CMP_R, OP_CMP_I5: begin
        res = arith[DATA_W-1:0];
        flg = arith_flags(arith);
        msk = MSK_ARITH;
      end
      OP_MUL_R: begin
        res = half_mul(src_b, a_low);
        wr  = 1'b1;
      end
      OP_MUL_I5: begin
        res = half_mul(src_b, ext_s5);
        wr  = 1'b1;
      end
      OP_MUL_I16: begin
        res = half_mul(src_b, ext_z16);
        wr  = 1'b1;
      end
      OP_AND_R: begin
        res = src_a & src_b;
        wr  = 1'b1;
        flg = logic_flags(src_a & src_b);
        msk = MSK_LOGIC;
      end
      OP_AND_I16: begin
        res = src_b & ext_z16;
        wr  = 1'b1;
        flg = {3'b000, (src_b & ext_z16) == '0};
        msk = MSK_LOGIC;
      end
      OP_OR_R: begin
        res = src_a | src_b;
        wr  = 1'b1;
        flg = logic_flags(src_a | src_b);
        msk = MSK_LOGIC;
      end
      OP_OR_I16: begin
        res = src_b | ext_z16;
        wr  = 1'b1;
        flg = logic_flags(src_b | ext_z16);
        msk = MSK_LOGIC;
      end
      OP_XOR_R: begin
        res = src_a ^ src_b;
        wr  = 1'b1;
        flg = logic_flags(src_a ^ src_b);
        msk = MSK_LOGIC;
      end
      OP_XOR_I16: begin
        res = src_b ^ ext_z16;
        wr  = 1'b1;
        flg = logic_flags(src_b ^ ext_z16);
        msk = MSK_LOGIC;
      end
      OP_NOT_R: begin
        res = ~src_a;
        wr  = 1'b1;
        flg = logic_flags(~src_a);
        msk = MSK_LOGIC;
      end
      OP_MOV_R: begin
        res = src_a;
        wr  = 1'b1;
      end
      OP_MOV_I5: begin
        res = ext_s5;
        wr  = 1'b1;
      end
      OP_MOVA_I16: begin
        res = src_b + ext_s16;
        wr  = 1'b1;
      end
      OP_MOVH_I16: begin
        res = src_b + ext_hi;
        wr  = 1'b1;
      end
      default: begin
        res = '0;
      end
    endcase
  end
endmodule

// File: rtl/alu_div_seq.sv
module alu_div_seq #(
  parameter int DATA_W = 32,
  parameter int DVS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DVS_W-1:0]  divisor,
  output logic              busy,
  output logic              done,
  output logic              dz,
  output logic              ovf,
  output logic [DATA_W-1:0] quot
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [CNT_W-1:0]  STEPS   = CNT_W'(DATA_W);

  typedef enum logic [1:0] {DV_IDLE, DV_RUN, DV_DONE} dv_state_e;

  dv_state_e         st_q;
  logic [DATA_W-1:0] rem_q, quo_q, mag_q;
  logic              neg_q, dz_q, ov_q;
  logic [CNT_W-1:0]  cnt_q;

  logic [DATA_W-1:0] dvs_x, dvd_mag, dvs_mag;
  logic [DATA_W:0]   rem_sh, rem_sub;
  logic              fits, start_dz, start_ov;
  logic              div_unused_top;

  assign dvs_x    = {{(DATA_W-DVS_W){divisor[DVS_W-1]}}, divisor};
  assign dvd_mag  = dividend[DATA_W-1] ? -dividend : dividend;
  assign dvs_mag  = dvs_x[DATA_W-1] ? -dvs_x : dvs_x;
  assign start_dz = (divisor == '0);
  assign start_ov = (dividend == MIN_NEG) && (&divisor);

  // one restoring step: shift in the next dividend bit and try the divisor
  assign rem_sh  = {rem_q, quo_q[DATA_W-1]};
  assign fits    = rem_sh >= {1'b0, mag_q};
  assign rem_sub = rem_sh - {1'b0, mag_q};
  assign div_unused_top = rem_sub[DATA_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= DV_IDLE;
      rem_q <= '0;
      quo_q <= '0;
      mag_q <= '0;
      neg_q <= 1'b0;
      dz_q  <= 1'b0;
      ov_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        DV_IDLE: begin
          if (start) begin
            neg_q <= dividend[DATA_W-1] ^ dvs_x[DATA_W-1];
            dz_q  <= start_dz;
            ov_q  <= start_ov;
            mag_q <= dvs_mag;
            rem_q <= '0;
            quo_q <= dvd_mag;
            cnt_q <= STEPS;
            st_q  <= (start_dz || start_ov) ? DV_DONE : DV_RUN;
          end
        end
        DV_RUN: begin
          rem_q <= fits ? rem_sub[DATA_W-1:0] : rem_sh[DATA_W-1:0];
          quo_q <= {quo_q[DATA_W-2:0], fits};
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) st_q <= DV_DONE;
        end
        default: st_q <= DV_IDLE;
      endcase
    end
  end

  assign busy = (st_q != DV_IDLE);
  assign done = (st_q == DV_DONE);
  assign dz   = dz_q;
  assign ovf  = ov_q;
  assign quot = ov_q ? MIN_NEG : (dz_q ? '0 : (neg_q ? -quo_q : quo_q));
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SIMM_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  output logic              op_ready,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_wr,
  output logic [FLG_W-1:0]  res_flags,
  output logic [FLG_W-1:0]  res_mask
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] ext_s5, ext_s16, ext_z16, ext_hi;
  logic [DATA_W-1:0] sc_res;
  logic              sc_wr;
  logic [FLG_W-1:0]  sc_flg, sc_msk;

  // named events for the checker
  logic acc_fire, acc_is_div, div_start, single_fire;
  logic div_busy, div_done, div_dz, div_ovf;
  logic [DATA_W-1:0] div_quot;
  logic [FLG_W-1:0]  div_flg, div_msk;

  assign op_ready    = !div_busy;
  assign acc_fire    = op_valid && op_ready;
  assign acc_is_div  = (op_code == OP_DIV_R);
  assign div_start   = acc_fire && acc_is_div;
  assign single_fire = acc_fire && !acc_is_div;

  alu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SIMM_W(SIMM_W)) u_ext (
    .imm(imm), .ext_s5(ext_s5), .ext_s16(ext_s16), .ext_z16(ext_z16), .ext_hi(ext_hi)
  );

  alu_single_cycle #(.DATA_W(DATA_W)) u_sc (
    .op(op_code), .src_a(src_a), .src_b(src_b),
    .ext_s5(ext_s5), .ext_s16(ext_s16), .ext_z16(ext_z16), .ext_hi(ext_hi),
    .res(sc_res), .wr(sc_wr), .flg(sc_flg), .msk(sc_msk)
  );

  alu_div_seq #(.DATA_W(DATA_W), .DVS_W(HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .dividend(src_b), .divisor(src_a[HALF-1:0]),
    .busy(div_busy), .done(div_done), .dz(div_dz), .ovf(div_ovf), .quot(div_quot)
  );

  always_comb begin
    if (div_dz) begin
      div_flg = 4'b1000;
      div_msk = MSK_DZERO;
    end else begin
      div_flg = {div_ovf, 1'b0, div_quot[DATA_W-1], div_quot == '0};
      div_msk = MSK_LOGIC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_wr    <= 1'b0;
      res_flags <= '0;
      res_mask  <= '0;
    end else begin
      res_valid <= single_fire || div_done;
      if (single_fire) begin
        res_data  <= sc_res;
        res_wr    <= sc_wr;
        res_flags <= sc_flg;
        res_mask  <= sc_msk;
      end else if (div_done) begin
        res_data  <= div_quot;
        res_wr    <= !div_dz;
        res_flags <= div_flg;
        res_mask  <= div_msk;
      end else begin
        res_wr    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_fire,
  input logic              div_start,
  input logic [OP_W-1:0]   op_code,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              op_ready,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic              res_wr,
  input logic [FLG_W-1:0]  res_flags,
  input logic [FLG_W-1:0]  res_mask
);
  // R12
  single_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && op_code != OP_DIV_R) |=> res_valid);
  // R12
  div_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |=> (!op_ready && !res_valid));
  // R4
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && (op_code == OP_CMP_R || op_code == OP_CMP_I5)) |=> (!res_wr && res_mask == 4'hF));
  // R5
  mul_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && (op_code == OP_MUL_R || op_code == OP_MUL_I5 || op_code == OP_MUL_I16))
      |=> (res_wr && res_mask == 4'h0));
  // R6
  logic_cy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && (op_code == OP_AND_R || op_code == OP_OR_R || op_code == OP_XOR_R
                  || op_code == OP_NOT_R || op_code == OP_OR_I16 || op_code == OP_XOR_I16))
      |=> (!res_mask[FC] && res_mask[FV] && !res_flags[FV]));
  // R11
  divzero_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_mask == 4'b1000) |-> (!res_wr && res_flags[FV]));
  // R2
  add_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && op_code == OP_ADD_R) |=>
      (res_flags[FV] == (($past(src_a[DATA_W-1]) == $past(src_b[DATA_W-1]))
                         && (res_data[DATA_W-1] != $past(src_a[DATA_W-1])))));
  // R2
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_wr && res_mask[FZ]) |-> (res_flags[FZ] == (res_data == '0)));
  // R13
  undef_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && op_code > 5'(OP_MOVH_I16)) |=> (res_valid && !res_wr && res_mask == 4'h0));
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.DATA_W(DATA_W)) u_alu_chk (
  .clk(clk), .rst_n(rst_n), .acc_fire(acc_fire), .div_start(div_start),
  .op_code(op_code), .src_a(src_a), .src_b(src_b), .op_ready(op_ready),
  .res_valid(res_valid), .res_data(res_data), .res_wr(res_wr),
  .res_flags(res_flags), .res_mask(res_mask)
);

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb_top;
  import alu_flag_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 31;

  typedef struct packed {
    logic [4:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] imm;
    logic [31:0] e_res;
    logic        e_wr;
    logic [3:0]  e_flg;
    logic [3:0]  e_msk;
    logic [3:0]  req;
  } vec_t;

  // flags {OV,CY,S,Z}
  localparam vec_t VEC [0:NV-1] = '{
    '{OP_ADD_R,    32'h7FFFFFFF, 32'h00000001, 16'h0000, 32'h80000000, 1'b1, 4'hA, 4'hF, 4'd2},  // R2
    '{OP_ADD_R,    32'hFFFFFFFF, 32'h00000001, 16'h0000, 32'h00000000, 1'b1, 4'h5, 4'hF, 4'd2},  // R2
    '{OP_ADD_I5,   32'h00000000, 32'h00000005, 16'h001F, 32'h00000004, 1'b1, 4'h4, 4'hF, 4'd2},  // R2
    '{OP_ADD_I16,  32'h00000000, 32'h00008000, 16'h8000, 32'h00000000, 1'b1, 4'h5, 4'hF, 4'd2},  // R2
    '{OP_SUB_R,    32'h00000001, 32'h80000000, 16'h0000, 32'h7FFFFFFF, 1'b1, 4'h8, 4'hF, 4'd3},  // R3
    '{OP_RSUB_R,   32'h00000003, 32'h00000005, 16'h0000, 32'hFFFFFFFE, 1'b1, 4'h6, 4'hF, 4'd3},  // R3
    '{OP_CMP_R,    32'h00000007, 32'h00000007, 16'h0000, 32'h00000000, 1'b0, 4'h1, 4'hF, 4'd4},  // R4
    '{OP_CMP_I5,   32'h00000000, 32'hFFFFFFF0, 16'h0010, 32'h00000000, 1'b0, 4'h1, 4'hF, 4'd4},  // R4
    '{OP_MUL_R,    32'hABCD0003, 32'h1234FFFF, 16'h0000, 32'h0002FFFD, 1'b1, 4'h0, 4'h0, 4'd5},  // R5
    '{OP_MUL_I5,   32'h00000000, 32'h00000005, 16'h001E, 32'hFFFFFFF6, 1'b1, 4'h0, 4'h0, 4'd5},  // R5
    '{OP_MUL_I16,  32'h00000000, 32'h0000FFFF, 16'hFFFF, 32'hFFFE0001, 1'b1, 4'h0, 4'h0, 4'd5},  // R5
    '{OP_AND_R,    32'hF0F0F0F0, 32'h80000000, 16'h0000, 32'h80000000, 1'b1, 4'h2, 4'hB, 4'd6},  // R6
    '{OP_OR_I16,   32'h00000000, 32'h80000000, 16'h1234, 32'h80001234, 1'b1, 4'h2, 4'hB, 4'd6},  // R6
    '{OP_XOR_R,    32'h5A5A5A5A, 32'h5A5A5A5A, 16'h0000, 32'h00000000, 1'b1, 4'h1, 4'hB, 4'd6},  // R6
    '{OP_XOR_I16,  32'h00000000, 32'hFFFFFFFF, 16'hFFFF, 32'hFFFF0000, 1'b1, 4'h2, 4'hB, 4'd6},  // R6
    '{OP_NOT_R,    32'hFFFFFFFF, 32'h00000000, 16'h0000, 32'h00000000, 1'b1, 4'h1, 4'hB, 4'd6},  // R6
    '{OP_OR_R,     32'h00000000, 32'h00000000, 16'h0000, 32'h00000000, 1'b1, 4'h1, 4'hB, 4'd6},  // R6
    '{OP_AND_I16,  32'h00000000, 32'h80000000, 16'hFFFF, 32'h00000000, 1'b1, 4'h1, 4'hB, 4'd7},  // R7
    '{OP_AND_I16,  32'h00000000, 32'hFFFF8001, 16'h8001, 32'h00008001, 1'b1, 4'h0, 4'hB, 4'd7},  // R7
    '{OP_MOV_R,    32'h13579BDF, 32'h00000000, 16'h0000, 32'h13579BDF, 1'b1, 4'h0, 4'h0, 4'd8},  // R8
    '{OP_MOV_I5,   32'h00000000, 32'h00000000, 16'h0010, 32'hFFFFFFF0, 1'b1, 4'h0, 4'h0, 4'd8},  // R8
    '{OP_MOVA_I16, 32'h00000000, 32'h00000010, 16'hFFFE, 32'h0000000E, 1'b1, 4'h0, 4'h0, 4'd8},  // R8
    '{OP_MOVH_I16, 32'h00000000, 32'h00005678, 16'h1234, 32'h12345678, 1'b1, 4'h0, 4'h0, 4'd8},  // R8
    '{OP_DIV_R,    32'h00000007, 32'h00000064, 16'h0000, 32'h0000000E, 1'b1, 4'h0, 4'hB, 4'd9},  // R9
    '{OP_DIV_R,    32'h0000FFFE, 32'hFFFFFFF9, 16'h0000, 32'h00000003, 1'b1, 4'h0, 4'hB, 4'd9},  // R9
    '{OP_DIV_R,    32'h12340003, 32'hFFFFFFF7, 16'h0000, 32'hFFFFFFFD, 1'b1, 4'h2, 4'hB, 4'd9},  // R9
    '{OP_DIV_R,    32'h00000005, 32'h00000003, 16'h0000, 32'h00000000, 1'b1, 4'h1, 4'hB, 4'd9},  // R9
    '{OP_DIV_R,    32'h00008000, 32'h80000000, 16'h0000, 32'h00010000, 1'b1, 4'h0, 4'hB, 4'd9},  // R9
    '{OP_DIV_R,    32'h0000FFFF, 32'h80000000, 16'h0000, 32'h80000000, 1'b1, 4'hA, 4'hB, 4'd10}, // R10
    '{OP_DIV_R,    32'hABCD0000, 32'h00000005, 16'h0000, 32'h00000000, 1'b0, 4'h8, 4'h8, 4'd11}, // R11
    '{5'd31,       32'h12345678, 32'h9ABCDEF0, 16'hFFFF, 32'h00000000, 1'b0, 4'h0, 4'h0, 4'd13}  // R13
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [15:0] imm = '0;
  logic        op_ready, res_valid, res_wr;
  logic [31:0] res_data;
  logic [3:0]  res_flags, res_mask;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .imm(imm), .op_ready(op_ready),
    .res_valid(res_valid), .res_data(res_data), .res_wr(res_wr),
    .res_flags(res_flags), .res_mask(res_mask)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_result(output int waited);
    waited = 0;
    while (!res_valid && waited < 200) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic run_vec(input int i);
    int w;
    logic [40:0] act, exp;
    @(negedge clk);
    op_code  = VEC[i].op;
    src_a    = VEC[i].a;
    src_b    = VEC[i].b;
    imm      = VEC[i].imm;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    wait_result(w);
    act = {res_valid, res_data, res_wr, res_flags, res_mask};
    exp = {1'b1, VEC[i].e_res, VEC[i].e_wr, VEC[i].e_flg, VEC[i].e_msk};
    check(act == exp, $sformatf("R%0d", VEC[i].req), $sformatf("vector %0d", i),
          64'(act), 64'(exp));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      errors++;
      $display("FAIL R12 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int extra;
    int w;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!res_valid && !res_wr && op_ready, "R1", "in reset {valid,wr,ready}",
          64'({res_valid, res_wr, op_ready}), 64'(3'b001));
    rst_n = 1'b1;
    @(negedge clk);
    // R1 after reset
    check(!res_valid && !res_wr && op_ready, "R1", "after reset {valid,wr,ready}",
          64'({res_valid, res_wr, op_ready}), 64'(3'b001));

    for (int i = 0; i < NV; i++) run_vec(i);

    // R12 back-to-back single-cycle operations, one cycle each
    @(negedge clk);
    op_code = OP_ADD_R; src_a = 32'd2; src_b = 32'd3; op_valid = 1'b1;
    @(negedge clk);
    check(res_valid && res_data == 32'd5, "R12", "first back-to-back result",
          64'({res_valid, res_data}), 64'({1'b1, 32'd5}));
    op_code = OP_SUB_R; src_a = 32'd1; src_b = 32'd10;
    @(negedge clk);
    check(res_valid && res_data == 32'd9, "R12", "second back-to-back result",
          64'({res_valid, res_data}), 64'({1'b1, 32'd9}));
    op_valid = 1'b0;
    @(negedge clk);
    check(!res_valid, "R12", "no pulse without operation", 64'(res_valid), 64'(0));

    // R12 operation offered during divide is dropped
    @(negedge clk);
    op_code = OP_DIV_R; src_a = 32'd2; src_b = 32'd40; op_valid = 1'b1;
    @(negedge clk);
    check(!op_ready, "R12", "op_ready during divide", 64'(op_ready), 64'(0));
    op_code = OP_ADD_R; src_a = 32'd1; src_b = 32'd1;
    repeat (5) @(negedge clk);
    op_valid = 1'b0;
    wait_result(w);
    check(res_valid && res_data == 32'h14 && res_wr && res_mask == 4'hB, "R12",
          "divide result after blocked offer",
          64'({res_valid, res_data, res_wr, res_mask}),
          64'({1'b1, 32'h14, 1'b1, 4'hB}));
    extra = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (res_valid) extra++;
    end
    check(extra == 0, "R12", "pulses from dropped offer", 64'(extra), 64'(0));
    check(op_ready, "R12", "op_ready after divide", 64'(op_ready), 64'(1));

    // R1 reset mid-divide returns to idle
    @(negedge clk);
    op_code = OP_DIV_R; src_a = 32'd3; src_b = 32'd99; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(!res_valid && op_ready, "R1", "reset aborts divide {valid,ready}",
          64'({res_valid, op_ready}), 64'(2'b01));
    rst_n = 1'b1;

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule